// File: doc/BRIEF.md
# Serial Receiver with Mute and Wake-Up

This block receives asynchronous serial frames of one start bit, eight data bits sent least significant bit first, and one stop bit. The line is sampled on a 16x oversampling tick that comes from an outside baud source. A valid low start bit must still be low at its midpoint. Each data bit and the stop bit are sampled at their midpoints. A completed byte goes into a receive register and raises a data-ready flag. If a byte completes while the previous one is still unread, an overrun flag is raised instead and the old byte is kept. An idle flag is raised once when the line stays high for a whole frame time after received data.

The block can be put into a mute state, in which bytes meant for other listeners are dropped without raising any flag. The wake source is selected by one input. In idle mode, a full idle frame on the line ends the mute state. In address mode, a byte with its top bit set ends the mute state, and that byte is delivered. Software requests to change the mute bit are refused in two cases. In idle mode, entering mute is refused until a byte has arrived. In address mode, any change is refused while unread data is pending. One interrupt request combines the data, overrun and idle conditions, each gated by its own enable.

Top module: `sci_mute_rx`

## Requirements
- R1: A frame with a low start bit, 8 data bits sent LSB first and a high stop bit loads the byte into `rx_data` and sets `rdrf`; a one-cycle `rd_strobe` clears `rdrf`.
- R2: While `rx_en` is 0, no frame is received and `rdrf` stays 0.
- R3: A low pulse on `rxd` that has ended by the middle of the start bit is discarded. A frame whose stop bit is sampled low is discarded, and no flag changes.
- R4: If a frame completes while `rdrf` is 1, `ovr` is set and `rx_data` keeps the older byte; `rd_strobe` clears both `rdrf` and `ovr`.
- R5: `irq` equals (`rie` AND (`rdrf` OR `ovr`)) OR (`ilie` AND `idle`).
- R6: After an accepted byte, `idle` is set once the line has been high and no frame has been in progress for 16*(8+2) oversampling ticks. It is not set again until another byte is accepted. `rd_strobe` clears it.
- R7: While `rwu` is 1, frames that do not wake the receiver leave `rdrf`, `ovr` and `idle` unchanged.
- R8: With `wake_sel` = 0 (idle mode), a write of 1 to `rwu` is ignored until a byte has been accepted since `rx_en` last rose. After that, writes to `rwu` take effect.
- R9: In idle mode, while muted, a full idle frame clears `rwu`, and that idle period does not set `idle`.
- R10: With `wake_sel` = 1 (address mode), writes to `rwu` are ignored while `rdrf` is 1.
- R11: In address mode, while muted, a frame whose bit 7 is 1 clears `rwu`, loads `rx_data` and sets `rdrf`. Idle periods do not clear `rwu` in this mode.
- R12: After reset, `rdrf`, `ovr`, `idle`, `rwu` and `irq` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| os_tick | input | 1 | 16x oversampling tick |
| rxd | input | 1 | Serial line, idle high |
| rx_en | input | 1 | Receiver enable |
| wake_sel | input | 1 | Wake source: 0 idle line, 1 address mark |
| rie | input | 1 | Enables the data-ready and overrun interrupts |
| ilie | input | 1 | Enables the idle interrupt |
| rwu_wr | input | 1 | Write strobe for the mute bit |
| rwu_wdata | input | 1 | Value written to the mute bit |
| rd_strobe | input | 1 | Data register read; clears the flags |
| rx_data | output | 8 | Received byte |
| rdrf | output | 1 | Receive data ready |
| ovr | output | 1 | Overrun |
| idle | output | 1 | Idle line detected |
| rwu | output | 1 | Mute state |
| irq | output | 1 | Interrupt request |

## Verification
The hardest situation to reach is an idle-line wake-up. It needs the receiver to have accepted a byte since it was enabled, then to be muted after that byte's idle period has already ended, then to see a muted frame followed by a new idle gap. The bench toggles `rx_en` to clear the history of received bytes, shows that a mute request is refused at that point, and receives one byte. It clears the resulting idle flag with a read, then mutes, sends an ignored frame and waits out a full idle frame. In address mode, the bench leaves a byte unread on purpose so that the blocked mute write can be seen at the ports.

// File: rtl/sci_rx_pkg.sv
package sci_rx_pkg;
   typedef enum logic [1:0] {
      SMP_IDLE  = 2'd0,
      SMP_START = 2'd1,
      SMP_DATA  = 2'd2,
      SMP_STOP  = 2'd3
   } smp_state_e;
endpackage

// File: rtl/rx_bit_sampler.sv
module rx_bit_sampler
   import sci_rx_pkg::*;
#(
   parameter int DATA_BITS   = 8,
   parameter int OVS         = 16,
   parameter int SYNC_STAGES = 2
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 en,
   input  logic                 os_tick,
   input  logic                 rxd,
   output logic                 rxd_s,
   output logic                 busy,
   output logic                 frame_ok,
   output logic [DATA_BITS-1:0] frame_data
);
   localparam int CW   = $clog2(OVS);
   localparam int BW   = $clog2(DATA_BITS);
   localparam int MID  = OVS / 2 - 1;
   localparam int LAST = OVS - 1;

   // input synchronizer, depth chosen by parameter
   generate
      if (SYNC_STAGES == 0) begin : g_nosync
         assign rxd_s = rxd;
      end else begin : g_sync
         logic [SYNC_STAGES-1:0] stg;
         for (genvar g = 0; g < SYNC_STAGES; g++) begin : g_stage
            if (g == 0) begin : g_first
               always_ff @(posedge clk or negedge rst_n)
                  if (!rst_n) stg[g] <= 1'b1;
                  else        stg[g] <= rxd;
            end else begin : g_next
               always_ff @(posedge clk or negedge rst_n)
                  if (!rst_n) stg[g] <= 1'b1;
                  else        stg[g] <= stg[g-1];
            end
         end
         assign rxd_s = stg[SYNC_STAGES-1];
      end
   endgenerate

   smp_state_e           state;
   logic [CW-1:0]        cnt;
   logic [BW-1:0]        bidx;
   logic [DATA_BITS-1:0] shreg;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state    <= SMP_IDLE;
         cnt      <= '0;
         bidx     <= '0;
         shreg    <= '0;
         frame_ok <= 1'b0;
      end else begin
         frame_ok <= 1'b0;
         if (!en) begin
            state <= SMP_IDLE;
            cnt   <= '0;
         end else if (os_tick) begin
            unique case (state)
               SMP_IDLE: begin
                  if (!rxd_s) begin
                     state <= SMP_START;
                     cnt   <= '0;
                  end
               end
               SMP_START: begin
                  if (cnt == CW'(MID)) begin
                     cnt   <= '0;
                     bidx  <= '0;
                     state <= rxd_s ? SMP_IDLE : SMP_DATA;
                  end else begin
                     cnt <= cnt + 1'b1;
                  end
               end
               SMP_DATA: begin
                  if (cnt == CW'(LAST)) begin
                     cnt   <= '0;
                     shreg <= {rxd_s, shreg[DATA_BITS-1:1]};
                     if (bidx == BW'(DATA_BITS - 1)) state <= SMP_STOP;
                     else                            bidx  <= bidx + 1'b1;
                  end else begin
                     cnt <= cnt + 1'b1;
                  end
               end
               SMP_STOP: begin
                  if (cnt == CW'(LAST)) begin
                     cnt      <= '0;
                     state    <= SMP_IDLE;
                     frame_ok <= rxd_s;
                  end else begin
                     cnt <= cnt + 1'b1;
                  end
               end
               default: state <= SMP_IDLE;
            endcase
         end
      end
   end

   assign busy       = (state != SMP_IDLE);
   assign frame_data = shreg;
endmodule

// File: rtl/rx_idle_det.sv
module rx_idle_det #(
   parameter int FRAME_TICKS = 160
) (
   input  logic clk,
   input  logic rst_n,
   input  logic en,
   input  logic os_tick,
   input  logic line_hi,
   output logic idle_evt
);
   localparam int TW = $clog2(FRAME_TICKS + 1);

   logic [TW-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt      <= '0;
         idle_evt <= 1'b0;
      end else if (!en || !line_hi) begin
         cnt      <= '0;
         idle_evt <= 1'b0;
      end else if (os_tick && cnt != TW'(FRAME_TICKS)) begin
         cnt      <= cnt + 1'b1;
         idle_evt <= (cnt == TW'(FRAME_TICKS - 1));
      end else begin
         idle_evt <= 1'b0;
      end
   end

   // R6
   idle_needs_line_chk: assert property (@(posedge clk) disable iff (!rst_n)
      idle_evt |-> $past(line_hi));
endmodule

// File: rtl/rx_mute_ctl.sv
module rx_mute_ctl (
   input  logic clk,
   input  logic rst_n,
   input  logic en,
   input  logic wake_sel,
   input  logic rwu_wr,
   input  logic rwu_wdata,
   input  logic rdrf,
   input  logic byte_seen,
   input  logic idle_evt,
   input  logic addr_mark,
   output logic rwu,
   output logic hw_wake
);
   logic got_byte;
   logic sw_ok;

   assign hw_wake = rwu && (wake_sel ? addr_mark : idle_evt);
   assign sw_ok   = rwu_wr
                    && !(wake_sel && rdrf)
                    && !(!wake_sel && rwu_wdata && !got_byte);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         got_byte <= 1'b0;
         rwu      <= 1'b0;
      end else begin
         if (!en)            got_byte <= 1'b0;
         else if (byte_seen) got_byte <= 1'b1;
         if (hw_wake)        rwu <= 1'b0;
         else if (sw_ok)     rwu <= rwu_wdata;
      end
   end

   // R8
   rwu_set_by_sw_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rwu) |-> $past(rwu_wr && rwu_wdata));
   // R10
   rwu_locked_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wake_sel && rdrf && rwu_wr && !hw_wake) |=> $stable(rwu));
endmodule

// File: rtl/sci_mute_rx.sv
module sci_mute_rx #(
   parameter int DATA_BITS   = 8,
   parameter int OVS         = 16,
   parameter int SYNC_STAGES = 2
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 os_tick,
   input  logic                 rxd,
   input  logic                 rx_en,
   input  logic                 wake_sel,
   input  logic                 rie,
   input  logic                 ilie,
   input  logic                 rwu_wr,
   input  logic                 rwu_wdata,
   input  logic                 rd_strobe,
   output logic [DATA_BITS-1:0] rx_data,
   output logic                 rdrf,
   output logic                 ovr,
   output logic                 idle,
   output logic                 rwu,
   output logic                 irq
);
   localparam int FRAME_TICKS = OVS * (DATA_BITS + 2);

   generate
      if (OVS < 4 || (OVS % 2) != 0) begin : g_bad_ovs
         $error("OVS must be even and at least 4");
      end
      if (DATA_BITS < 5 || DATA_BITS > 9) begin : g_bad_bits
         $error("DATA_BITS must lie between 5 and 9");
      end
      if (SYNC_STAGES < 0 || SYNC_STAGES > 4) begin : g_bad_sync
         $error("SYNC_STAGES must lie between 0 and 4");
      end
   endgenerate

   logic                 rxd_s, busy, frame_ok, idle_evt, hw_wake;
   logic [DATA_BITS-1:0] frame_data;
   logic                 addr_mark, accept, armed;

   rx_bit_sampler #(
      .DATA_BITS  (DATA_BITS),
      .OVS        (OVS),
      .SYNC_STAGES(SYNC_STAGES)
   ) u_smp (
      .clk       (clk),
      .rst_n     (rst_n),
      .en        (rx_en),
      .os_tick   (os_tick),
      .rxd       (rxd),
      .rxd_s     (rxd_s),
      .busy      (busy),
      .frame_ok  (frame_ok),
      .frame_data(frame_data)
   );

   rx_idle_det #(
      .FRAME_TICKS(FRAME_TICKS)
   ) u_idle (
      .clk     (clk),
      .rst_n   (rst_n),
      .en      (rx_en),
      .os_tick (os_tick),
      .line_hi (rxd_s && !busy),
      .idle_evt(idle_evt)
   );

   assign addr_mark = frame_ok && frame_data[DATA_BITS-1];
   assign accept    = frame_ok && (!rwu || (wake_sel && frame_data[DATA_BITS-1]));

   rx_mute_ctl u_mute (
      .clk      (clk),
      .rst_n    (rst_n),
      .en       (rx_en),
      .wake_sel (wake_sel),
      .rwu_wr   (rwu_wr),
      .rwu_wdata(rwu_wdata),
      .rdrf     (rdrf),
      .byte_seen(accept),
      .idle_evt (idle_evt),
      .addr_mark(addr_mark),
      .rwu      (rwu),
      .hw_wake  (hw_wake)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rx_data <= '0;
         rdrf    <= 1'b0;
         ovr     <= 1'b0;
         idle    <= 1'b0;
         armed   <= 1'b0;
      end else begin
         if (rd_strobe) begin
            rdrf <= 1'b0;
            ovr  <= 1'b0;
            idle <= 1'b0;
         end
         if (accept) begin
            armed <= 1'b1;
            if (rdrf && !rd_strobe) begin
               ovr <= 1'b1;
            end else begin
               rx_data <= frame_data;
               rdrf    <= 1'b1;
            end
         end else if (idle_evt) begin
            armed <= 1'b0;
            if (armed && !rwu) idle <= 1'b1;
         end
      end
   end

   assign irq = (rie && (rdrf || ovr)) || (ilie && idle);

   // R4
   ovr_needs_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ovr) |-> $past(rdrf));
   // R4
   data_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rdrf) && !$past(rd_strobe)) |-> $stable(rx_data));
   // R7
   mute_no_rdrf_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rdrf) |-> (!$past(rwu) || wake_sel));
   // R7
   mute_no_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(idle) |-> !$past(rwu));
endmodule

// File: tb/sci_mute_rx_bench.sv
module sci_mute_rx_bench;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       rxd = 1'b1;
   logic       rx_en = 1'b0;
   logic       wake_sel = 1'b0;
   logic       rie = 1'b0;
   logic       ilie = 1'b0;
   logic       rwu_wr = 1'b0;
   logic       rwu_wdata = 1'b0;
   logic       rd_strobe = 1'b0;
   logic [7:0] rx_data;
   logic       rdrf, ovr, idle, rwu, irq;

   int   checks = 0, errors = 0;
   int   mon_checks = 0, mon_errs = 0;
   int   req_cnt = 0, done_cnt = 0;
   logic auto_rd = 1'b0;
   logic [7:0] exp_q[$];

   always #2.5 clk = ~clk;

   sci_mute_rx u_sci_mute_rx (
      .clk(clk), .rst_n(rst_n), .os_tick(1'b1), .rxd(rxd), .rx_en(rx_en),
      .wake_sel(wake_sel), .rie(rie), .ilie(ilie), .rwu_wr(rwu_wr),
      .rwu_wdata(rwu_wdata), .rd_strobe(rd_strobe), .rx_data(rx_data),
      .rdrf(rdrf), .ovr(ovr), .idle(idle), .rwu(rwu), .irq(irq)
   );

   // monitor: pops expected bytes and drives the read strobe
   always @(negedge clk) begin
      rd_strobe = 1'b0;
      if (auto_rd && rdrf) begin
         mon_checks++;
         if (exp_q.size() == 0) begin
            mon_errs++;
            $display("FAIL R1: unexpected byte %h, expected none", rx_data);
         end else begin
            logic [7:0] e;
            e = exp_q.pop_front();
            if (rx_data !== e) begin
               mon_errs++;
               $display("FAIL R1: rx_data %h, expected %h", rx_data, e);
            end
         end
         rd_strobe = 1'b1;
      end else if (req_cnt != done_cnt) begin
         rd_strobe = 1'b1;
         done_cnt++;
      end
   end

   task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %h, expected %h", req, act, exp);
      end
   endtask

   task automatic wait_cyc(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic send_frame(input logic [7:0] b, input bit expect_it, input bit stop_hi = 1'b1);
      if (expect_it) exp_q.push_back(b);
      @(negedge clk); rxd = 1'b0;
      wait_cyc(16);
      for (int i = 0; i < 8; i++) begin
         rxd = b[i];
         wait_cyc(16);
      end
      rxd = stop_hi;
      wait_cyc(16);
      rxd = 1'b1;
      wait_cyc(2);
   endtask

   task automatic do_read();
      req_cnt++;
      wait_cyc(3);
   endtask

   task automatic write_rwu(input logic v);
      @(negedge clk); rwu_wr = 1'b1; rwu_wdata = v;
      @(negedge clk); rwu_wr = 1'b0;
   endtask

   task automatic run_tests();
      // R12 reset state
      wait_cyc(4);
      chk("R12 rdrf", rdrf, 0); chk("R12 ovr", ovr, 0); chk("R12 idle", idle, 0);
      chk("R12 rwu", rwu, 0);   chk("R12 irq", irq, 0);
      rst_n = 1'b1; rx_en = 1'b1; auto_rd = 1'b1;
      wait_cyc(4);

      // R1 several data patterns through the scoreboard
      send_frame(8'hA5, 1); send_frame(8'h3C, 1);
      send_frame(8'h00, 1); send_frame(8'hFF, 1);
      wait_cyc(4);
      chk("R1 rdrf cleared by read", rdrf, 0);

      // R3 glitch and bad stop bit
      @(negedge clk); rxd = 1'b0; wait_cyc(4); rxd = 1'b1; wait_cyc(40);
      chk("R3 glitch", rdrf, 0);
      auto_rd = 1'b0;
      send_frame(8'h5E, 0, 1'b0); wait_cyc(30);
      chk("R3 framing rdrf", rdrf, 0); chk("R3 framing ovr", ovr, 0);
      auto_rd = 1'b1;
      send_frame(8'h81, 1); wait_cyc(4);

      // R2 disabled receiver
      wait_cyc(200); do_read();
      rx_en = 1'b0; auto_rd = 1'b0;
      send_frame(8'h42, 0); wait_cyc(4);
      chk("R2 disabled", rdrf, 0);
      rx_en = 1'b1; wait_cyc(4);

      // R4 / R5 overrun and interrupt
      rie = 1'b1;
      send_frame(8'h11, 0);
      chk("R5 irq on rdrf", irq, 1); chk("R1 data", rx_data, 8'h11);
      send_frame(8'h22, 0);
      chk("R4 ovr", ovr, 1); chk("R4 old data kept", rx_data, 8'h11);
      chk("R5 irq", irq, 1);
      do_read();
      chk("R4 rdrf cleared", rdrf, 0); chk("R4 ovr cleared", ovr, 0);
      chk("R5 irq low", irq, 0);
      rie = 1'b0;

      // R6 idle flag
      wait_cyc(200);
      chk("R6 idle set", idle, 1);
      chk("R5 irq idle gated off", irq, 0);
      ilie = 1'b1; wait_cyc(1);
      chk("R5 irq on idle", irq, 1);
      do_read(); wait_cyc(200);
      chk("R6 idle once", idle, 0);
      ilie = 1'b0;

      // R8 / R7 / R9 idle wake mode
      wake_sel = 1'b0; auto_rd = 1'b1;
      rx_en = 1'b0; wait_cyc(2); rx_en = 1'b1; wait_cyc(2);
      write_rwu(1'b1); wait_cyc(1);
      chk("R8 mute refused", rwu, 0);
      send_frame(8'h5A, 1); wait_cyc(200);
      do_read();
      write_rwu(1'b1); wait_cyc(1);
      chk("R8 mute accepted", rwu, 1);
      send_frame(8'h77, 0); wait_cyc(2);
      chk("R7 muted rdrf", rdrf, 0); chk("R9 still muted", rwu, 1);
      wait_cyc(200);
      chk("R9 idle wake", rwu, 0); chk("R9 no idle flag", idle, 0);
      send_frame(8'h66, 1); wait_cyc(4);
      wait_cyc(200); do_read();

      // R10 / R11 address mode
      wake_sel = 1'b1; auto_rd = 1'b0;
      send_frame(8'h40, 0);
      chk("R1 data addr mode", rx_data, 8'h40);
      write_rwu(1'b1); wait_cyc(1);
      chk("R10 write blocked", rwu, 0);
      do_read();
      write_rwu(1'b1); wait_cyc(1);
      chk("R10 write allowed", rwu, 1);
      send_frame(8'h12, 0);
      chk("R7 muted addr rdrf", rdrf, 0);
      wait_cyc(200);
      chk("R11 idle no wake", rwu, 1);
      chk("R7 muted idle", idle, 0);
      send_frame(8'h85, 0);
      chk("R11 wake", rwu, 0); chk("R11 rdrf", rdrf, 1);
      chk("R11 data", rx_data, 8'h85);
      do_read();
      chk("R1 queue drained", 8'(exp_q.size()), 0);
   endtask

   initial begin
      bit done = 0;
      fork
         begin run_tests(); done = 1; end
         begin repeat (150000) @(posedge clk); end
      join_any
      disable fork;
      if (!done) begin
         checks++; errors++;
         $display("FAIL watchdog: actual timeout, expected completion");
      end
      $display("Simulation finished: %0d checks, %0d errors",
               checks + mon_checks, errors + mon_errs);
      $finish;
   end
endmodule